// File: doc/BRIEF.md
# Byte/Word/Long Shift-Rotate Unit

This unit performs the single-instruction shift and rotate operations of a small CPU datapath. An operand of 8, 16 or 32 bits arrives together with an operation select, a control byte that carries the shift distance, and the current carry flag. One to two positions later, it returns the moved value and the updated sign, zero, overflow and carry flags. There are eight operations: logical shift left and right, arithmetic shift left and right, plain rotate left and right, and rotate left and right through the carry.

Requests enter through a valid/ready handshake. A request that is accepted is computed in one combinational pass. The result is captured in an output register and is presented with a valid strobe on the next cycle. A two-state controller governs the output register. The state `ST_EMPTY` means no result is held and the unit is always ready. The state `ST_FULL` means a result is presented. The transition `ST_EMPTY -> ST_FULL` occurs on an accepted request. The transition `ST_FULL -> ST_EMPTY` occurs when the result is taken and no new request arrives. The transition `ST_FULL -> ST_FULL` occurs when a result is taken and a new request is accepted in the same cycle. While the result is not taken, the unit also stays in `ST_FULL` and holds the result.

Top module: `shift_rot_unit`

## Requirements
- R1: `size_sel` picks the operand width: 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 selects 32 bits. Operand bits above the selected width have no effect on any output.
- R2: The shift distance is 2 positions when bit 6 of `ctrl_byte` is 1 and 1 position when it is 0. All other `ctrl_byte` bits are ignored.
- R3: `op_sel` 0 selects logical left and 1 selects logical right. Vacated positions fill with 0, and C takes the last bit moved out: bit msb-1 or bit 1 for a distance of 2.
- R4: `op_sel` 3 selects arithmetic right. The sign bit is kept and copied into every vacated high position, and C takes the last bit moved out of the low end.
- R5: `op_sel` 2 selects arithmetic left. Vacated positions fill with 0, C takes the last bit moved out of the top, and V is 1 exactly when the sign bit changes at any of the single-position steps.
- R6: `op_sel` 4 selects plain rotate left and 5 selects plain rotate right. Each bit moved out wraps into the vacated end, and C ends equal to the last bit moved out.
- R7: `op_sel` 6 selects rotate left through carry and 7 selects rotate right through carry. At each step, the carry before that step enters the vacated end and the bit moved out becomes the new carry.
- R8: V is 0 for every operation other than arithmetic left.
- R9: N equals the top bit of the result at the selected width. Z is 1 exactly when the result bits at that width are all 0. Result bits above the selected width are 0.
- R10: A request is accepted when `in_valid` and `in_ready` are both high. `in_ready` is high whenever no result is held or `out_ready` is high. The result appears with `out_valid` on the cycle after acceptance and stays stable until it is taken. Reset clears `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can accept a request |
| size_sel | input | 2 | Operand width select |
| op_sel | input | 3 | Operation select |
| ctrl_byte | input | 8 | Control byte; bit 6 selects the distance |
| operand | input | 32 | Value to shift or rotate |
| carry_in | input | 1 | Current carry flag |
| out_valid | output | 1 | Result held and presented |
| out_ready | input | 1 | Consumer takes the result |
| result | output | 32 | Shifted or rotated value, zero above the width |
| flag_n | output | 1 | Sign flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |

## Verification
A directed sweep runs every operation at each width and at both distances. It uses operands whose top and bottom bits differ (`8000_0001`, `4000_0000`, `A5C3_96F1`) and all-zero operands. This separates which end feeds C and whether the fill is 0, the sign bit, the wrapped bit or the old carry. Operands with bits 7/6 or 15/14 set in one and clear in the other expose the two-step overflow rule, and a lone set sign bit shifted right twice exposes sign replication. Random operands with garbage above the width, random control bytes with bit 6 varied, and random carry inputs then run under random `in_valid` and `out_ready`. This shows that ignored bits stay ignored and that held results do not move during back-pressure.

// File: rtl/sru_pkg.sv
package sru_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_LONG_ALT = 2'd3
    } sz_e;

    typedef enum logic [2:0] {
        OP_LSL = 3'd0,
        OP_LSR = 3'd1,
        OP_ASL = 3'd2,
        OP_ASR = 3'd3,
        OP_ROL = 3'd4,
        OP_ROR = 3'd5,
        OP_RCL = 3'd6,
        OP_RCR = 3'd7
    } op_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } st_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

endpackage

// File: rtl/sru_core.sv
module sru_core #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] operand,
    input  logic [1:0]    size_sel,
    input  logic [2:0]    op_sel,
    input  logic          two_step,
    input  logic          carry_in,
    output logic [DW-1:0] moved,
    output logic          c_out,
    output logic          v_out
);
    import sru_pkg::*;

    localparam int IW = $clog2(DW);
    localparam int STEPS = 2;

    logic [DW-1:0] mask;
    logic [DW-1:0] sign_pos;
    logic [IW-1:0] msb;
    logic [DW-1:0] acc;
    logic          hi;
    logic          lo;
    logic          cy;
    logic          ovf;

    // width window for the selected size
    always_comb begin
        unique case (sz_e'(size_sel))
            SZ_BYTE: begin
                mask = DW'(8'hFF);
                msb  = IW'(7);
            end
            SZ_WORD: begin
                mask = DW'(16'hFFFF);
                msb  = IW'(15);
            end
            default: begin
                mask = '1;
                msb  = IW'(DW - 1);
            end
        endcase
        sign_pos = mask ^ (mask >> 1);
    end

    // one or two single-position steps applied in sequence
    always_comb begin
        acc = operand & mask;
        cy  = carry_in;
        ovf = 1'b0;
        hi  = 1'b0;
        lo  = 1'b0;
        for (int s = 0; s < STEPS; s++) begin
            if (s == 0 || two_step) begin
                hi = acc[msb];
                lo = acc[0];
                unique case (op_e'(op_sel))
                    OP_LSL: begin
                        acc = (acc << 1) & mask;
                        cy  = hi;
                    end
                    OP_ASL: begin
                        if (hi != acc[msb - IW'(1)]) ovf = 1'b1;
                        acc = (acc << 1) & mask;
                        cy  = hi;
                    end
                    OP_LSR: begin
                        acc = acc >> 1;
                        cy  = lo;
                    end
                    OP_ASR: begin
                        acc = (acc >> 1) | (hi ? sign_pos : '0);
                        cy  = lo;
                    end
                    OP_ROL: begin
                        acc = ((acc << 1) & mask) | {{(DW-1){1'b0}}, hi};
                        cy  = hi;
                    end
                    OP_ROR: begin
                        acc = (acc >> 1) | (lo ? sign_pos : '0);
                        cy  = lo;
                    end
                    OP_RCL: begin
                        acc = ((acc << 1) & mask) | {{(DW-1){1'b0}}, cy};
                        cy  = hi;
                    end
                    OP_RCR: begin
                        acc = (acc >> 1) | (cy ? sign_pos : '0);
                        cy  = lo;
                    end
                endcase
            end
        end
        moved = acc;
        c_out = cy;
        v_out = ovf;
    end

endmodule

// File: rtl/sru_flags.sv
module sru_flags #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] value,
    input  logic [1:0]    size_sel,
    output logic          neg,
    output logic          zero
);
    import sru_pkg::*;

    logic [DW-1:0] window;

    always_comb begin
        unique case (sz_e'(size_sel))
            SZ_BYTE: window = DW'(8'hFF);
            SZ_WORD: window = DW'(16'hFFFF);
            default: window = '1;
        endcase
        neg  = |(value & (window ^ (window >> 1)));
        zero = ~|(value & window);
    end

endmodule

// File: rtl/shift_rot_unit.sv
module shift_rot_unit #(
    parameter int DW = 32,
    parameter int DIST_BIT = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [1:0]    size_sel,
    input  logic [2:0]    op_sel,
    input  logic [7:0]    ctrl_byte,
    input  logic [DW-1:0] operand,
    input  logic          carry_in,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] result,
    output logic          flag_n,
    output logic          flag_z,
    output logic          flag_v,
    output logic          flag_c
);
    import sru_pkg::*;

    st_e           state_q;
    st_e           state_d;
    logic          accept;
    logic [DW-1:0] moved;
    logic          c_new;
    logic          v_new;
    logic          n_new;
    logic          z_new;
    logic [DW-1:0] res_q;
    flags_t        flg_q;

    sru_core #(.DW(DW)) u_core (
        .operand  (operand),
        .size_sel (size_sel),
        .op_sel   (op_sel),
        .two_step (ctrl_byte[DIST_BIT]),
        .carry_in (carry_in),
        .moved    (moved),
        .c_out    (c_new),
        .v_out    (v_new)
    );

    sru_flags #(.DW(DW)) u_flags (
        .value    (moved),
        .size_sel (size_sel),
        .neg      (n_new),
        .zero     (z_new)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (in_valid)                state_d = ST_FULL;
            ST_FULL:  if (out_ready && !in_valid)  state_d = ST_EMPTY;
        endcase
    end

    // outputs of the controller
    always_comb begin
        out_valid = (state_q == ST_FULL);
        in_ready  = (state_q == ST_EMPTY) || out_ready;
        accept    = in_valid && in_ready;
    end

    // result register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
            flg_q <= '0;
        end else if (accept) begin
            res_q <= moved;
            flg_q <= '{n: n_new, z: z_new, v: v_new, c: c_new};
        end
    end

    assign result = res_q;
    assign flag_n = flg_q.n;
    assign flag_z = flg_q.z;
    assign flag_v = flg_q.v;
    assign flag_c = flg_q.c;

endmodule

// File: rtl/sru_checker.sv
module sru_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_ready,
    input logic [2:0]  op_sel,
    input logic        out_valid,
    input logic        out_ready,
    input logic [31:0] result,
    input logic        flag_z,
    input logic        flag_v,
    input logic        flag_c
);
    logic [2:0] held_op;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    held_op <= 3'd0;
        else if (in_valid && in_ready) held_op <= op_sel;
    end

    AST_RESULT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid); // R10

    AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(result) && $stable(flag_c) && $stable(flag_v))); // R10

    AST_READY_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready); // R10

    AST_ZERO_MATCHES_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (flag_z == (result == 32'd0))); // R9

    AST_V_ONLY_ARITH_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && held_op != 3'd2) |-> !flag_v); // R8

endmodule

bind shift_rot_unit sru_checker u_chk (.*);

// File: tb/shift_rot_unit_bench.sv
module shift_rot_unit_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic        in_ready;
    logic [1:0]  size_sel;
    logic [2:0]  op_sel;
    logic [7:0]  ctrl_byte;
    logic [31:0] operand;
    logic        carry_in;
    logic        out_valid;
    logic        out_ready;
    logic [31:0] result;
    logic        flag_n, flag_z, flag_v, flag_c;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [35:0] q_exp[$];
    int          q_op[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    shift_rot_unit u_shift_rot_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .size_sel(size_sel), .op_sel(op_sel), .ctrl_byte(ctrl_byte),
        .operand(operand), .carry_in(carry_in), .out_valid(out_valid),
        .out_ready(out_ready), .result(result), .flag_n(flag_n),
        .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
    );

    function automatic string op_tag(int op);
        case (op)
            0, 1:    return "R3";
            3:       return "R4";
            2:       return "R5";
            4, 5:    return "R6";
            default: return "R7";
        endcase
    endfunction

    // behavioural reference: integer arithmetic over the width
    function automatic logic [35:0] ref_calc(int sz, int op, bit two, bit cin, logic [31:0] a);
        int w;
        longint unsigned full, half, x, top, bot;
        bit c, v, old;
        w = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
        full = longint'(1) << w;
        half = full / 2;
        x = longint'(a) % full;
        c = cin;
        v = 0;
        for (int k = 0; k < (two ? 2 : 1); k++) begin
            top = x / half;
            bot = x % 2;
            old = c;
            case (op)
                0: begin c = top[0]; x = (x * 2) % full; end
                2: begin c = top[0]; x = (x * 2) % full; if ((x / half) != top) v = 1; end
                1: begin c = bot[0]; x = x / 2; end
                3: begin c = bot[0]; x = x / 2 + top * half; end
                4: begin c = top[0]; x = (x * 2) % full + top; end
                5: begin c = bot[0]; x = x / 2 + bot * half; end
                6: begin c = top[0]; x = (x * 2) % full + longint'(old); end
                default: begin c = bot[0]; x = x / 2 + longint'(old) * half; end
            endcase
        end
        return {x[31:0], (x / half) == 1, x == 0, v, c};
    endfunction

    // cycle-level model of the handshake
    always @(posedge clk) begin
        if (!rst_n) begin
            q_exp.delete();
            q_op.delete();
        end else begin
            bit had, acc;
            had = (q_exp.size() != 0);
            acc = in_valid && (!had || out_ready);
            if (had && out_ready) begin
                void'(q_exp.pop_front());
                void'(q_op.pop_front());
            end
            if (acc) begin
                q_exp.push_back(ref_calc(int'(size_sel), int'(op_sel), ctrl_byte[6], carry_in, operand));
                q_op.push_back(int'(op_sel));
            end
        end
    end

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        bit hv;
        hv = (q_exp.size() != 0);
        check(out_valid == hv, "R10 out_valid", 32'(out_valid), 32'(hv));
        check(in_ready == (!hv || out_ready), "R10 in_ready", 32'(in_ready), 32'(!hv || out_ready));
        if (hv && out_valid) begin
            logic [35:0] e;
            string t;
            e = q_exp[0];
            t = op_tag(q_op[0]);
            check(result == e[35:4], {t, "/R1/R2 result"}, result, e[35:4]);
            check(flag_n == e[3], "R9 N", 32'(flag_n), 32'(e[3]));
            check(flag_z == e[2], "R9 Z", 32'(flag_z), 32'(e[2]));
            check(flag_v == e[1], (q_op[0] == 2) ? "R5 V" : "R8 V", 32'(flag_v), 32'(e[1]));
            check(flag_c == e[0], {t, " C"}, 32'(flag_c), 32'(e[0]));
        end
    endtask

    task automatic step();
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] pats [4];
        pats[0] = 32'h8000_0001;
        pats[1] = 32'h4000_0000;
        pats[2] = 32'hA5C3_96F1;
        pats[3] = 32'h0000_0000;
        rst_n = 0; in_valid = 0; out_ready = 1; size_sel = 0; op_sel = 0;
        ctrl_byte = 0; operand = 0; carry_in = 0;
        repeat (3) @(negedge clk);
        // reset state: R10
        check(out_valid == 1'b0, "R10 reset out_valid", 32'(out_valid), 32'd0);
        check(in_ready == 1'b1, "R10 reset in_ready", 32'(in_ready), 32'd1);
        check(result == 32'd0, "R10 reset result", result, 32'd0);
        rst_n = 1;
        step();

        // directed sweep: every op, width and distance (R1..R9)
        for (int sz = 0; sz < 3; sz++)
            for (int op = 0; op < 8; op++)
                for (int d = 0; d < 2; d++)
                    for (int p = 0; p < 4; p++) begin
                        in_valid  = 1;
                        size_sel  = 2'(sz);
                        op_sel    = 3'(op);
                        ctrl_byte = d ? 8'h40 : 8'hBF;
                        operand   = (sz == 0) ? (pats[p] >> 24) | (pats[p] << 24)
                                  : (sz == 1) ? (pats[p] >> 16) | (pats[p] << 16) : pats[p];
                        carry_in  = p[0];
                        step();
                    end

        // sign-bit corner cases: 0x80 arithmetic right by 2, 0x40 arithmetic left (R4, R5)
        op_sel = 3; size_sel = 0; ctrl_byte = 8'h40; operand = 32'hFFFF_FF80; step();
        op_sel = 2; size_sel = 0; ctrl_byte = 8'h40; operand = 32'h0000_0040; step();
        op_sel = 2; size_sel = 1; ctrl_byte = 8'h00; operand = 32'h0000_C000; step();
        op_sel = 2; size_sel = 3; ctrl_byte = 8'h40; operand = 32'h2000_0000; step();
        in_valid = 0;
        step();

        // random traffic with back-pressure and garbage in ignored bits (R1, R2, R10)
        repeat (2000) begin
            in_valid  = ($urandom % 3) != 0;
            out_ready = ($urandom % 4) != 0;
            size_sel  = 2'($urandom);
            op_sel    = 3'($urandom);
            ctrl_byte = 8'($urandom);
            operand   = $urandom;
            carry_in  = 1'($urandom);
            step();
        end

        in_valid = 0;
        out_ready = 1;
        step();
        step();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule